// File: doc/BRIEF.md
# Debug Scan Register Access Unit

This unit sits behind a JTAG TAP data register on the target side. A debugger reaches a small bank of debug registers through it, one 38-bit scan at a time. Each scan carries a 32-bit data word, a 5-bit register address and a 1-bit direction flag. When the TAP passes through update-DR with the flag set, the word is written to the addressed register. Every update latches the address as the pending address. The next capture-DR loads the contents of the pending register into the data field. A read therefore spans two scans.

The bank holds a debug control register, which drives a monitor-mode enable, and a debug status register that reflects a core-supplied status word. It also holds two watch units of value/mask storage. A comms mailbox links the host and the core. The host writes a word that the core consumes. The core posts a word that the host consumes. Two flags, one for each direction, report which words are waiting. Capturing the mailbox data register consumes the core's word. The host must therefore leave the control register addressed on its last scan.

Top module: `dbg_scan_access`

## Requirements
- R1: The scan register is 38 bits and shifts toward `tdo`, which shows its bit 0. The data field is bits 31:0 and leaves first, LSB first. The address is bits 36:32. The flag is bit 37. Capture loads the read word into bits 31:0 and zeros into bits 37:32.
- R2: An update with flag 1 writes the data field to the addressed register. An update with flag 0 writes nothing.
- R3: Every update latches its address as the pending address. A capture returns the register at the pending address.
- R4: A capture while the pending address is 5 (mailbox data) clears the core-to-host flag. A capture at address 4 (mailbox control) leaves both flags unchanged.
- R5: Mailbox control (address 4) reads as follows: bits 31:28 hold the version parameter, bit 1 the core-to-host flag, bit 0 the host-to-core flag, and all other bits zero. Writes to it are ignored.
- R6: A host write to address 5 loads the host-to-core word and sets `core_h2c_full`. A `core_h2c_rd` pulse clears it, unless a host write to address 5 happens in the same cycle.
- R7: A `core_c2h_wr` pulse loads the core-to-host word and sets `core_c2h_full`. A capture of address 5 then returns that word. The core write wins over a capture in the same cycle.
- R8: Debug control (address 0) stores the low 6 bits of a write. Bits 31:6 read as zero. Bit 4 drives `monitor_en`.
- R9: Debug status (address 1) reads `dbg_status_i` in bits 4:0, with zeros above. Writes to it are ignored.
- R10: Watch unit u (0 or 1) has six 32-bit read/write registers at addresses 8+8u to 13+8u.
- R11: Any other address reads as zero and ignores writes.
- R12: After reset, all stored registers, both flags, the pending address and `monitor_en` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TAP clock |
| rst_n | input | 1 | Active-low reset |
| capture_dr | input | 1 | TAP in capture-DR, this register selected |
| shift_dr | input | 1 | TAP in shift-DR, this register selected |
| update_dr | input | 1 | TAP in update-DR, this register selected |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| core_h2c_rd | input | 1 | Core takes the host-to-core word |
| core_h2c_data | output | 32 | Host-to-core word |
| core_h2c_full | output | 1 | Host-to-core word waiting |
| core_c2h_wr | input | 1 | Core posts a word for the host |
| core_c2h_data | input | 32 | Word posted by the core |
| core_c2h_full | output | 1 | Core-to-host word waiting |
| dbg_status_i | input | 5 | Core debug status |
| monitor_en | output | 1 | Monitor mode enable |

## Verification
The bench sweeps writes and chained reads over all 32 addresses. A decoder that aliases addresses, or leaks writes into the read-only and unmapped slots, shows up as a wrong readback. Each capture is checked against the register addressed by the previous update. A design that returned the current scan's address would fail every chained read.

The mailbox is driven through the double-read hazard. With the pending address left on data, a fresh core word is lost at the next capture. With control left as the pending address, the word stays waiting. A design that consumed on control, or never consumed, would show wrong flag bits in the control readback. A flag-0 scan and writes to control, status and unmapped slots check that nothing changes.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
    localparam int ADR_DCTRL    = 0;
    localparam int ADR_DSTAT    = 1;
    localparam int ADR_CCTRL    = 4;
    localparam int ADR_CDATA    = 5;
    localparam int WATCH_BASE   = 8;
    localparam int WATCH_STRIDE = 8;
    localparam int WATCH_REGS   = 6;
    localparam int DCTRL_W      = 6;
    localparam int DSTAT_W      = 5;
    localparam int MON_BIT      = 4;
    localparam int VER_W        = 4;
endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              tdi,
    input  logic [DATA_W-1:0] cap_word,
    output logic              tdo,
    output logic [DATA_W-1:0] fld_data,
    output logic [ADDR_W-1:0] fld_addr,
    output logic              fld_wr
);
    localparam int SCAN_W = DATA_W + ADDR_W + 1;

    logic [SCAN_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (capture_en)
            sr_d = {{(ADDR_W+1){1'b0}}, cap_word};
        else if (shift_en)
            sr_d = {tdi, sr_q[SCAN_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign tdo      = sr_q[0];
    assign fld_data = sr_q[DATA_W-1:0];
    assign fld_addr = sr_q[DATA_W +: ADDR_W];
    assign fld_wr   = sr_q[SCAN_W-1];
endmodule

// File: rtl/dbg_comms_mbox.sv
module dbg_comms_mbox #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_consume,
    input  logic              core_rd,
    input  logic              core_wr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] h2c_word,
    output logic [DATA_W-1:0] c2h_word,
    output logic              h2c_full,
    output logic              c2h_full
);
    typedef struct packed {
        logic [DATA_W-1:0] h2c;
        logic [DATA_W-1:0] c2h;
        logic              h2c_full;
        logic              c2h_full;
    } mbox_t;

    mbox_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (core_rd) st_d.h2c_full = 1'b0;
        if (host_wr) begin
            st_d.h2c      = host_wdata;
            st_d.h2c_full = 1'b1;
        end
        if (host_consume) st_d.c2h_full = 1'b0;
        if (core_wr) begin
            st_d.c2h      = core_wdata;
            st_d.c2h_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h2c_word = st_q.h2c;
    assign c2h_word = st_q.c2h;
    assign h2c_full = st_q.h2c_full;
    assign c2h_full = st_q.c2h_full;
endmodule

// File: rtl/dbg_watch_bank.sv
module dbg_watch_bank
    import dbg_scan_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int NUM_WATCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit
);
    localparam int SLOTS = NUM_WATCH * WATCH_REGS;

    logic [DATA_W-1:0] mem_d [SLOTS];
    logic [DATA_W-1:0] mem_q [SLOTS];
    logic [SLOTS-1:0]  wsel, rsel;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam int SLOT_ADR = WATCH_BASE + (g / WATCH_REGS) * WATCH_STRIDE + (g % WATCH_REGS);
        assign wsel[g] = (wr_addr == ADDR_W'(SLOT_ADR));
        assign rsel[g] = (rd_addr == ADDR_W'(SLOT_ADR));
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++)
            mem_d[i] = (wr_en && wsel[i]) ? wr_data : mem_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SLOTS; i++)
            if (rsel[i]) rd_data = rd_data | mem_q[i];
    end
    assign rd_hit = |rsel;
endmodule

// File: rtl/dbg_scan_access.sv
module dbg_scan_access
    import dbg_scan_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 5,
    parameter int          NUM_WATCH = 2,
    parameter logic [3:0]  VERSION   = 4'd6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture_dr,
    input  logic                 shift_dr,
    input  logic                 update_dr,
    input  logic                 tdi,
    output logic                 tdo,
    input  logic                 core_h2c_rd,
    output logic [DATA_W-1:0]    core_h2c_data,
    output logic                 core_h2c_full,
    input  logic                 core_c2h_wr,
    input  logic [DATA_W-1:0]    core_c2h_data,
    output logic                 core_c2h_full,
    input  logic [DSTAT_W-1:0]   dbg_status_i,
    output logic                 monitor_en
);
    localparam logic [ADDR_W-1:0] A_DCTRL = ADDR_W'(ADR_DCTRL);
    localparam logic [ADDR_W-1:0] A_DSTAT = ADDR_W'(ADR_DSTAT);
    localparam logic [ADDR_W-1:0] A_CCTRL = ADDR_W'(ADR_CCTRL);
    localparam logic [ADDR_W-1:0] A_CDATA = ADDR_W'(ADR_CDATA);

    typedef struct packed {
        logic [DCTRL_W-1:0] ctrl;
        logic [ADDR_W-1:0]  pend;
    } top_t;

    top_t st_d, st_q;

    logic [DATA_W-1:0] scan_data, rd_word, watch_rd, c2h_word;
    logic [ADDR_W-1:0] scan_addr;
    logic              scan_flag, watch_hit, host_wr, host_wr_data, host_consume;

    assign host_wr      = update_dr && scan_flag;
    assign host_wr_data = host_wr && (scan_addr == A_CDATA);
    assign host_consume = capture_dr && (st_q.pend == A_CDATA);

    dbg_scan_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .capture_en(capture_dr), .shift_en(shift_dr), .tdi(tdi),
        .cap_word(rd_word), .tdo(tdo),
        .fld_data(scan_data), .fld_addr(scan_addr), .fld_wr(scan_flag)
    );

    dbg_comms_mbox #(.DATA_W(DATA_W)) u_mbox (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr_data), .host_wdata(scan_data),
        .host_consume(host_consume),
        .core_rd(core_h2c_rd), .core_wr(core_c2h_wr), .core_wdata(core_c2h_data),
        .h2c_word(core_h2c_data), .c2h_word(c2h_word),
        .h2c_full(core_h2c_full), .c2h_full(core_c2h_full)
    );

    dbg_watch_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WATCH(NUM_WATCH)) u_watch (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_wr), .wr_addr(scan_addr), .wr_data(scan_data),
        .rd_addr(st_q.pend), .rd_data(watch_rd), .rd_hit(watch_hit)
    );

    always_comb begin
        st_d = st_q;
        if (update_dr) st_d.pend = scan_addr;
        if (host_wr && scan_addr == A_DCTRL) st_d.ctrl = scan_data[DCTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_word = '0;
        if (st_q.pend == A_DCTRL)
            rd_word = DATA_W'(st_q.ctrl);
        else if (st_q.pend == A_DSTAT)
            rd_word = DATA_W'(dbg_status_i);
        else if (st_q.pend == A_CCTRL)
            rd_word = {VERSION, {(DATA_W-VER_W-2){1'b0}}, core_c2h_full, core_h2c_full};
        else if (st_q.pend == A_CDATA)
            rd_word = c2h_word;
        else if (watch_hit)
            rd_word = watch_rd;
    end

    assign monitor_en = st_q.ctrl[MON_BIT];
endmodule

// File: rtl/dbg_scan_access_chk.sv
module dbg_scan_access_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              capture_dr,
    input logic              update_dr,
    input logic              scan_flag,
    input logic [ADDR_W-1:0] scan_addr,
    input logic              mon_bit_in,
    input logic [ADDR_W-1:0] pend,
    input logic              core_h2c_rd,
    input logic              core_c2h_wr,
    input logic              h2c_full,
    input logic              c2h_full,
    input logic              monitor_en
);
    logic wr_data_hit, wr_ctrl_hit;
    assign wr_data_hit = update_dr && scan_flag && (scan_addr == ADDR_W'(5));
    assign wr_ctrl_hit = update_dr && scan_flag && (scan_addr == ADDR_W'(0));

    AST_HOST_WR_SETS_RX: assert property (@(posedge clk) disable iff (!rst_n) wr_data_hit |=> h2c_full); // R6
    AST_CORE_RD_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n) (core_h2c_rd && !wr_data_hit) |=> !h2c_full); // R6
    AST_CORE_WR_SETS_TX: assert property (@(posedge clk) disable iff (!rst_n) core_c2h_wr |=> c2h_full); // R7
    AST_DATA_CAPTURE_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n) (capture_dr && pend == ADDR_W'(5) && !core_c2h_wr) |=> !c2h_full); // R4
    AST_CTRL_CAPTURE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (capture_dr && pend == ADDR_W'(4) && !core_c2h_wr) |=> $stable(c2h_full)); // R4
    AST_MON_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_ctrl_hit |=> (monitor_en == $past(mon_bit_in))); // R8
    AST_MON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !wr_ctrl_hit |=> $stable(monitor_en)); // R2
    AST_PEND_LATCH: assert property (@(posedge clk) disable iff (!rst_n) update_dr |=> (pend == $past(scan_addr))); // R3
endmodule

bind dbg_scan_access dbg_scan_access_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .update_dr(update_dr),
    .scan_flag(scan_flag), .scan_addr(scan_addr), .mon_bit_in(scan_data[4]),
    .pend(st_q.pend), .core_h2c_rd(core_h2c_rd), .core_c2h_wr(core_c2h_wr),
    .h2c_full(core_h2c_full), .c2h_full(core_c2h_full), .monitor_en(monitor_en)
);

// File: tb/dbg_scan_access_test.sv
module dbg_scan_access_test;
    localparam logic [3:0] VER = 4'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo;
    logic core_h2c_rd = 0, core_c2h_wr = 0;
    logic [31:0] core_h2c_data, core_c2h_data = '0;
    logic core_h2c_full, core_c2h_full, monitor_en;
    logic [4:0] dbg_status_i = '0;

    always #5 clk = ~clk;

    dbg_scan_access uut (
        .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .core_h2c_rd(core_h2c_rd), .core_h2c_data(core_h2c_data), .core_h2c_full(core_h2c_full),
        .core_c2h_wr(core_c2h_wr), .core_c2h_data(core_c2h_data), .core_c2h_full(core_c2h_full),
        .dbg_status_i(dbg_status_i), .monitor_en(monitor_en)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_watch [32];
    logic [5:0]  m_ctrl = '0;
    logic [31:0] m_h2c = '0, m_c2h = '0;
    logic        m_rx = 0, m_tx = 0;
    logic [4:0]  m_pend = '0;

    function automatic bit is_watch(int a);
        return (a >= 8 && a <= 13) || (a >= 16 && a <= 21);
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        case (a)
            0: return {26'b0, m_ctrl};
            1: return {27'b0, dbg_status_i};
            4: return {VER, 26'b0, m_tx, m_rx};
            5: return m_c2h;
            default: return is_watch(a) ? m_watch[a] : 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] pat(int a);
        return 32'h9E37_79B1 * (a + 3) ^ 32'h0F0F_1234;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one full capture/shift/update pass; checks the captured word
    task automatic scan(int addr, logic [31:0] data, logic flag, string tag);
        logic [37:0] vec, cap;
        logic [31:0] e;
        vec = {flag, 5'(addr), data};
        e = exp_rd(int'(m_pend));
        @(negedge clk) capture_dr = 1;
        @(negedge clk) capture_dr = 0;
        if (m_pend == 5'd5) m_tx = 0;
        shift_dr = 1;
        for (int i = 0; i < 38; i++) begin
            tdi = vec[i];
            cap[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 0;
        update_dr = 1;
        @(negedge clk) update_dr = 0;
        check({tag, " capture data"}, 64'(cap[31:0]), 64'(e));
        check("R1 capture upper zero", 64'(cap[37:32]), 64'h0);
        if (flag) begin
            if (addr == 0) m_ctrl = data[5:0];
            else if (addr == 5) begin m_h2c = data; m_rx = 1; end
            else if (is_watch(addr)) m_watch[addr] = data;
        end
        m_pend = 5'(addr);
    endtask

    task automatic core_post(logic [31:0] w);
        @(negedge clk) begin core_c2h_wr = 1; core_c2h_data = w; end
        @(negedge clk) core_c2h_wr = 0;
        m_c2h = w; m_tx = 1;
        check("R7 c2h full after post", 64'(core_c2h_full), 64'h1);
    endtask

    task automatic core_take();
        check("R6 h2c word", 64'(core_h2c_data), 64'(m_h2c));
        check("R6 h2c full before take", 64'(core_h2c_full), 64'(m_rx));
        @(negedge clk) core_h2c_rd = 1;
        @(negedge clk) core_h2c_rd = 0;
        m_rx = 0;
        check("R6 h2c full after take", 64'(core_h2c_full), 64'h0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_watch[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12 reset tdo", 64'(tdo), 64'h0);
        check("R12 reset monitor", 64'(monitor_en), 64'h0);
        check("R12 reset h2c full", 64'(core_h2c_full), 64'h0);
        check("R12 reset c2h full", 64'(core_c2h_full), 64'h0);
        dbg_status_i = 5'h16;

        // R12 / R5: first capture reads pending addr 0 after reset
        scan(4, 32'h0, 0, "R12 reset read");
        scan(4, 32'h0, 0, "R5 ctrl version");

        // write sweep over every address (R2 R8 R9 R10 R11, R5 ignores writes)
        for (int a = 0; a < 32; a++) scan(a, pat(a), 1, "R2 write sweep");
        check("R8 monitor after sweep", 64'(monitor_en), 64'(m_ctrl[4]));
        core_take();

        // read sweep: chained reads, with a core word waiting at addr 5
        core_post(32'hC0DE_0001);
        for (int a = 0; a < 32; a++) scan(a, 32'hFFFF_FFFF, 0, "R3 R10 R11 read sweep");
        scan(4, 32'h0, 0, "R4 R7 read of last");
        scan(4, 32'h0, 0, "R4 flags after sweep");

        // R2: flag 0 leaves watch slot untouched
        scan(8, 32'hDEAD_BEEF, 0, "R2 flag0");
        scan(13, 32'hDEAD_BEEF, 0, "R2 flag0 readback");
        scan(21, 32'h1234_5678, 1, "R10 last slot write");
        scan(21, 32'h0, 0, "R10");
        scan(4, 32'h0, 0, "R10 last slot readback");

        // R8 monitor enable
        scan(0, 32'hFFFF_FFFF, 1, "R8");
        check("R8 monitor on", 64'(monitor_en), 64'h1);
        scan(0, 32'h0000_002F, 1, "R8");
        check("R8 monitor off", 64'(monitor_en), 64'h0);
        scan(4, 32'h0, 0, "R8 ctrl readback");

        // R4: control as final address keeps a new word waiting
        core_post(32'hA000_0001);
        scan(5, 32'h0, 0, "R4");
        scan(4, 32'h0, 0, "R7 data captured");
        core_post(32'hA000_0002);
        scan(4, 32'h0, 0, "R4 ctrl keeps tx");
        check("R4 c2h still full", 64'(core_c2h_full), 64'h1);
        // R4: data left addressed loses the next word
        scan(5, 32'h0, 0, "R4");
        scan(5, 32'h0, 0, "R4 data read");
        core_post(32'hA000_0003);
        scan(4, 32'h0, 0, "R4 extra read consumes");
        check("R4 c2h consumed", 64'(core_c2h_full), 64'h0);
        scan(4, 32'h0, 0, "R5 flags clear");

        // R6: host data write then core take, plus ctrl bit0
        scan(5, 32'h5555_AAAA, 1, "R6 host write");
        scan(4, 32'h0, 0, "R6");
        scan(4, 32'hFFFF_FFFF, 1, "R5 ctrl shows rx");
        core_take();
        scan(4, 32'h0, 0, "R5 rx cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule